// File: doc/BRIEF.md
# Masked Parallel GPIO Output Bank

This block holds one output latch per GPIO pin and drives those latches onto a pad output vector. A simple register bus reaches the same latches through two windows. The per-pin window gives each pin its own byte. The masked window gives a 32-bit word for each group of 16 consecutive pins: the upper half is a mask and the lower half carries the data. Software can therefore set or clear any subset of a group in one write, with no read-modify-write.

A third window returns the pad input levels, 32 pins per word, after a two-flop synchronizer. The pin count `NPINS` is a parameter and must be a multiple of 32.

The word address `addr` is `AW = 2 + clog2(NPINS/4)` bits wide. Its top two bits pick a region: 0 is per-pin, 1 is masked, 2 is input and 3 is unmapped. The low `AW-2` bits form the word index `idx`. Read data is registered, so it appears on `rdata` in the cycle after `rd_en`. A read returns the latch state from before any write in that same cycle.

Top module: `gpo_bank`

## Requirements
- R1: With `rst_n` low at a clock edge, every output latch clears, and `pad_out` and `rdata` read 0 after that edge.
- R2: A write to per-pin word `idx` with byte enable `be[k]` set loads the latch of pin `4*idx+k` from `wdata[8*k+7]`. All other `wdata` bits are ignored, and lanes whose `be[k]` is clear are left unchanged.
- R3: A read of per-pin word `idx` returns the latch of pin `4*idx+k` in bit `8*k+7` for k = 0..3. Every other bit reads 0, and so does any lane whose pin number is `NPINS` or more.
- R4: A write to masked word `m` with `wdata[16+i]` = 1 loads the latch of pin `16*m+i` from `wdata[i]`, for i = 0..15.
- R5: During a masked write, every pin whose mask bit is 0 keeps its latch value.
- R6: Any read of the masked region returns 0.
- R7: Both windows act on the same latches. A value written through either one is seen on `pad_out` and through a per-pin read.
- R8: A read of input word `n` returns in bit `b` the synchronized level of `pad_in[32*n+b]`, where 1 means high. A pad level applied before clock edge t can be read from edge t+2 on.
- R9: Region 3, masked indices of `NPINS/16` or more, and input indices of `NPINS/32` or more are unmapped. Writes to them change no latch, and reads of them return 0.
- R10: In a cycle with `rd_en` low, `rdata` reads 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Word address; top two bits select the region |
| be | input | 4 | Byte enables for per-pin writes |
| wdata | input | 32 | Write data |
| pad_in | input | NPINS | Pad input levels |
| rdata | output | 32 | Registered read data |
| pad_out | output | NPINS | Output latch values |

## Verification
Per-pin writes are tried with full, partial and empty byte enables, and with data whose lane bit 7 differs from its other bits. These show whether the correct bit and the correct lanes are decoded. Masked writes are tried with all-ones, sparse and empty masks over data that is both set and clear, which separates commit-where-set from keep-where-clear. Writes through one window followed by reads or `pad_out` checks through the other confirm that the storage is shared. Walking and changing pad patterns read immediately and two cycles later expose the synchronizer depth. Writes and reads at unmapped indices, followed by a long random mix, confirm that no stray decode touches a latch.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  typedef enum logic [1:0] {
    RG_PIN  = 2'd0,
    RG_MSK  = 2'd1,
    RG_IN   = 2'd2,
    RG_NONE = 2'd3
  } rgn_e;

  localparam int PIN_LANES = 4;
  localparam int MSK_SPAN  = 16;
  localparam int IN_SPAN   = 32;
  localparam int PIN_BIT   = 7;

  // word of the per-pin window that holds pin p
  function automatic int pin_word(int p);
    return p / PIN_LANES;
  endfunction

  // byte lane of pin p inside its per-pin word
  function automatic int pin_lane(int p);
    return p % PIN_LANES;
  endfunction

  // masked word that covers pin p
  function automatic int msk_word(int p);
    return p / MSK_SPAN;
  endfunction

  // slot of pin p inside its masked word
  function automatic int msk_slot(int p);
    return p % MSK_SPAN;
  endfunction
endpackage

// File: rtl/gpo_sync.sv
module gpo_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  // counts edges since reset so the depth check never looks into reset
  always_ff @(posedge clk) begin
    if (!rst_n)               warm_q <= 2'd0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  assign q = s2_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (q == $past(d, 2))); // R8
endmodule

// File: rtl/gpo_wdec.sv
module gpo_wdec #(
  parameter int NPINS = 512,
  parameter int IW    = 7
) (
  input  logic              wr_en,
  input  gpo_pkg::rgn_e     rgn,
  input  logic [IW-1:0]     idx,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [NPINS-1:0]  upd_en,
  output logic [NPINS-1:0]  upd_val,
  output logic [NPINS-1:0]  mk_en,
  output logic [NPINS-1:0]  mk_val
);
  logic [NPINS-1:0] pp_en;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int LN = gpo_pkg::pin_lane(p);
    localparam int PW = gpo_pkg::pin_word(p);
    localparam int MW = gpo_pkg::msk_word(p);
    localparam int SL = gpo_pkg::msk_slot(p);

    assign pp_en[p]   = wr_en && (rgn == gpo_pkg::RG_PIN) &&
                        (idx == IW'(PW)) && be[LN];
    assign mk_en[p]   = wr_en && (rgn == gpo_pkg::RG_MSK) &&
                        (idx == IW'(MW)) && wdata[gpo_pkg::MSK_SPAN + SL];
    assign mk_val[p]  = wdata[SL];
    assign upd_en[p]  = pp_en[p] | mk_en[p];
    assign upd_val[p] = pp_en[p] ? wdata[8*LN + gpo_pkg::PIN_BIT] : mk_val[p];
  end
endmodule

// File: rtl/gpo_rmux.sv
module gpo_rmux #(
  parameter int NPINS = 512,
  parameter int IW    = 7
) (
  input  gpo_pkg::rgn_e     rgn,
  input  logic [IW-1:0]     idx,
  input  logic [NPINS-1:0]  lat,
  input  logic [NPINS-1:0]  sync,
  output logic [31:0]       rd_val
);
  localparam int IN_WORDS = NPINS / gpo_pkg::IN_SPAN;

  always_comb begin
    rd_val = '0;
    case (rgn)
      gpo_pkg::RG_PIN: begin
        for (int k = 0; k < gpo_pkg::PIN_LANES; k++) begin
          if (int'(idx) * gpo_pkg::PIN_LANES + k < NPINS)
            rd_val[8*k + gpo_pkg::PIN_BIT] = lat[int'(idx) * gpo_pkg::PIN_LANES + k];
        end
      end
      gpo_pkg::RG_IN: begin
        if (int'(idx) < IN_WORDS) begin
          for (int b = 0; b < gpo_pkg::IN_SPAN; b++)
            rd_val[b] = sync[int'(idx) * gpo_pkg::IN_SPAN + b];
        end
      end
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/gpo_bank.sv
module gpo_bank #(
  parameter int NPINS = 512,
  parameter int AW    = 2 + $clog2(NPINS / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [31:0]       rdata,
  output logic [NPINS-1:0]  pad_out
);
  localparam int IW = AW - 2;

  gpo_pkg::rgn_e    rgn;
  logic [IW-1:0]    idx;
  logic [NPINS-1:0] lat_q, sync_q;
  logic [NPINS-1:0] upd_en, upd_val, mk_en, mk_val;
  logic [31:0]      rd_val, rdata_q;

  assign rgn = gpo_pkg::rgn_e'(addr[AW-1 -: 2]);
  assign idx = addr[IW-1:0];

  gpo_sync #(.W(NPINS)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (pad_in), .q (sync_q)
  );

  gpo_wdec #(.NPINS(NPINS), .IW(IW)) u_wdec (
    .wr_en (wr_en), .rgn (rgn), .idx (idx), .be (be), .wdata (wdata),
    .upd_en (upd_en), .upd_val (upd_val), .mk_en (mk_en), .mk_val (mk_val)
  );

  gpo_rmux #(.NPINS(NPINS), .IW(IW)) u_rmux (
    .rgn (rgn), .idx (idx), .lat (lat_q), .sync (sync_q), .rd_val (rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (lat_q & ~upd_en) | (upd_val & upd_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
    else            rdata_q <= '0;
  end

  assign rdata   = rdata_q;
  assign pad_out = lat_q;

  AST_KEEP_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q ^ $past(lat_q)) & ~$past(upd_en)) == '0); // R5
  AST_MASK_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mk_en) & (lat_q ^ $past(mk_val))) == '0); // R4
  AST_MSK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rgn == gpo_pkg::RG_MSK) |=> (rdata == 32'd0)); // R6
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rgn == gpo_pkg::RG_NONE) |=> (rdata == 32'd0)); // R9
  AST_PIN_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rgn == gpo_pkg::RG_PIN) |=> ((rdata & ~32'h8080_8080) == 32'd0)); // R3
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> (rdata == 32'd0)); // R10
endmodule

// File: tb/sim_gpo_bank.sv
module sim_gpo_bank;
  localparam int NP = 64;
  localparam int AW = 2 + $clog2(NP / 4);
  localparam int IW = AW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0;
  logic [NP-1:0] pad_in = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_out;

  gpo_bank #(.NPINS(NP)) u0 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
    .be (be), .wdata (wdata), .pad_in (pad_in), .rdata (rdata), .pad_out (pad_out)
  );

  always #5 clk = ~clk;

  int    compared = 0, mismatched = 0, cyc = 0;
  string cur_tag = "R1";
  bit    model_live = 1'b0;

  // behavioural reference
  bit          m_lat [NP];
  bit [NP-1:0] h1, h2;
  bit [31:0]   exp_rd;

  always @(posedge clk) begin
    int r, ix;
    r  = int'(addr[AW-1 -: 2]);
    ix = int'(addr[IW-1:0]);
    model_live = 1'b1;
    if (!rst_n) begin
      foreach (m_lat[i]) m_lat[i] = 1'b0;
      h1 = '0; h2 = '0; exp_rd = '0;
    end else begin
      exp_rd = '0;
      if (rd_en) begin
        if (r == 0) begin
          for (int k = 0; k < 4; k++)
            if (ix * 4 + k < NP) exp_rd[8*k+7] = m_lat[ix*4+k];
        end else if (r == 2 && ix < NP / 32) begin
          exp_rd = h2[ix*32 +: 32];
        end
      end
      if (wr_en) begin
        if (r == 0) begin
          for (int k = 0; k < 4; k++)
            if (be[k] && ix * 4 + k < NP) m_lat[ix*4+k] = wdata[8*k+7];
        end else if (r == 1 && ix < NP / 16) begin
          for (int i = 0; i < 16; i++)
            if (wdata[16+i]) m_lat[ix*16+i] = wdata[i];
        end
      end
      h2 = h1;
      h1 = pad_in;
    end
  end

  always @(negedge clk) begin
    bit [NP-1:0] ev;
    if (model_live) begin
      foreach (m_lat[i]) ev[i] = m_lat[i];
      compared++;
      if (pad_out !== ev) begin
        mismatched++;
        $display("FAIL %s pad_out act=%h exp=%h", cur_tag, pad_out, ev);
      end
      compared++;
      if (rdata !== exp_rd) begin
        mismatched++;
        $display("FAIL %s rdata act=%h exp=%h", cur_tag, rdata, exp_rd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      mismatched++;
      $display("FAIL %s watchdog act=%0d exp<=60000 cycles", cur_tag, cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic op(input bit w, input bit rd, input int r, input int ix,
                    input bit [3:0] b, input bit [31:0] d);
    @(negedge clk);
    wr_en = w; rd_en = rd;
    addr  = {2'(r), IW'(ix)};
    be = b; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, 4'h0, 32'h0);
  endtask

  task automatic setpad(input bit [NP-1:0] v);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    pad_in = v;
  endtask

  initial begin
    // R1: reset clears everything, pads toggling meanwhile
    cur_tag = "R1";
    pad_in = 64'hFFFF_0000_AAAA_5555;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    op(0, 1, 0, 0, 4'h0, 0); op(0, 1, 2, 0, 4'h0, 0); idle(1);

    // R2: per-pin writes with lane bit 7 and byte enables
    cur_tag = "R2";
    op(1, 0, 0, 0, 4'hF, 32'h8000_8080);
    op(1, 0, 0, 5, 4'b0101, 32'hFFFF_FFFF);
    op(1, 0, 0, 1, 4'hF, 32'h7F7F_7F7F);
    op(1, 0, 0, 2, 4'h0, 32'hFFFF_FFFF);
    op(1, 0, 0, 15, 4'hF, 32'h8080_8080);
    idle(1);

    // R3: per-pin readback with spare bits zero
    cur_tag = "R3";
    op(0, 1, 0, 0, 0, 0); op(0, 1, 0, 5, 0, 0); op(0, 1, 0, 1, 0, 0);
    op(0, 1, 0, 15, 0, 0); op(1, 1, 0, 0, 4'h1, 32'h0);
    op(0, 1, 0, 0, 0, 0); idle(1);

    // R4: masked commit where mask set
    cur_tag = "R4";
    op(1, 0, 1, 1, 0, 32'hFFFF_A5A5);
    op(1, 0, 1, 3, 0, 32'h8001_FFFF);
    op(1, 0, 1, 2, 0, 32'h00FF_0F0F);
    idle(1);

    // R7: shared storage seen through per-pin view
    cur_tag = "R7";
    for (int j = 4; j < 16; j++) op(0, 1, 0, j, 0, 0);
    op(1, 0, 0, 4, 4'hF, 32'h0000_0080);
    op(0, 1, 0, 4, 0, 0);
    idle(1);

    // R5: mask clear keeps latches
    cur_tag = "R5";
    op(1, 0, 1, 1, 0, 32'h0F0F_0000);
    op(1, 0, 1, 1, 0, 32'h0000_FFFF);
    op(1, 0, 1, 0, 0, 32'h000B_0000);
    op(1, 0, 1, 3, 0, 32'h0000_0000);
    for (int j = 0; j < 16; j++) op(0, 1, 0, j, 0, 0);

    // R6: masked reads return zero
    cur_tag = "R6";
    for (int j = 0; j < 16; j++) op(0, 1, 1, j, 0, 0);
    idle(1);

    // R8: synchronized input view
    cur_tag = "R8";
    setpad(64'h1234_5678_9ABC_DEF0);
    op(0, 1, 2, 0, 0, 0); op(0, 1, 2, 1, 0, 0);
    op(0, 1, 2, 0, 0, 0); op(0, 1, 2, 1, 0, 0);
    for (int b = 0; b < NP; b += 7) begin
      setpad(64'd1 << b);
      op(0, 1, 2, b / 32, 0, 0);
      op(0, 1, 2, b / 32, 0, 0);
    end

    // R9: unmapped addresses
    cur_tag = "R9";
    for (int j = 0; j < 16; j++) op(1, 1, 3, j, 4'hF, 32'hFFFF_FFFF);
    for (int j = NP / 16; j < 16; j++) op(1, 1, 1, j, 4'hF, 32'hFFFF_FFFF);
    for (int j = NP / 32; j < 16; j++) op(1, 1, 2, j, 4'hF, 32'hFFFF_FFFF);
    idle(1);

    // R10: idle cycles give zero read data
    cur_tag = "R10";
    op(0, 1, 0, 0, 0, 0); idle(3);

    // random mix over all regions
    cur_tag = "R7";
    for (int n = 0; n < 2000; n++) begin
      if ((n % 9) == 0) pad_in = {$urandom, $urandom};
      op(1'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 16),
         4'($urandom), $urandom);
    end
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule